// File: doc/BRIEF.md
# Page write programming sequencer

This block sits between the serial command decoder of an SPI memory and its storage array. When the decoder recognises an array write, it passes the 12-bit start address and then each data byte as it completes. The sequencer collects up to 32 bytes in a page buffer. Nothing reaches the array until the host deselects the device. When chip select returns high on a byte boundary, a self-timed programming cycle begins. For its whole length the sequencer raises a busy flag, which the status unit reports as the write-in-progress bit.

The buffer is committed one byte per clock in the last 32 clocks of the window. The array is therefore updated by the time busy drops. At that point a single-cycle pulse tells the status unit to clear its write-enable latch. The cycle length is given in clock cycles by a parameter, so a test can shorten it. The array is modelled as RAM, and every byte reads 0xFF until it is first programmed.

The byte slot advances inside the aligned 32-byte page. Address bits 11:5 stay fixed and bits 4:0 count modulo 32. A chip-select release in the middle of a byte cancels the write. A release before any data byte also cancels it.

Top module: `pgm_sequencer`

## Requirements
- R1: After reset, busy_o and wel_clr_o are 0 and every array address reads 0xFF on rd_data_o.
- R2: In a write that has received at least one data byte, chip select is sampled rising (cs_n_i 0 then 1) with byte_aligned_i=1. busy_o becomes 1 on the next clock edge.
- R3: busy_o stays 1 for exactly CYCLE_CLKS clock cycles and then returns to 0.
- R4: wel_clr_o is 1 for exactly one cycle: the first cycle in which busy_o is 0 again.
- R5: The byte with index i of a write that starts at address A lands at {A[11:5], (A[4:0]+i) mod 32}. It is readable on rd_data_o once busy_o has fallen.
- R6: A write that sends more than 32 bytes wraps inside its page. For each slot, the last byte sent to that slot is the one kept.
- R7: Bytes that a write does not address keep their previous value. This holds for bytes in the same page and in every other page. A byte that has never been programmed reads 0xFF.
- R8: If chip select rises while byte_aligned_i=0, the write is discarded. No busy, no wel_clr_o pulse and no array change follow.
- R9: If chip select rises before any data byte has arrived, no programming cycle starts and the array is unchanged.
- R10: While busy_o is 1, wr_start_i, wr_byte_vld_i and chip-select edges have no effect on the array or on the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low, synchronous to clk_i |
| wr_start_i | input | 1 | Decoder pulse: array write decoded, address valid |
| wr_addr_i | input | ADDR_W | Start address of the write |
| wr_byte_vld_i | input | 1 | Decoder pulse: one data byte complete |
| wr_byte_i | input | 8 | Data byte |
| byte_aligned_i | input | 1 | Decoder bit counter is at a byte boundary |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array read data (combinational) |
| busy_o | output | 1 | Programming cycle in progress (write-in-progress) |
| wel_clr_o | output | 1 | One-cycle pulse clearing the write-enable latch |

## Verification
Chip select is raised before edge E0. busy_o is due 1 after E0 and is sampled at the following falling edge. The bench then counts falling edges. busy_o must still be 1 at the CYCLE_CLKS-th one and must be 0 with wel_clr_o at 1 at the next. wel_clr_o must be back to 0 one cycle later. Array contents are compared only after busy_o has dropped, because the commit finishes at that same edge. The read port is combinational, so each read is sampled 1 ns after its address is driven while the sequencer is idle. For discarded writes, the bench watches busy_o and wel_clr_o over a full cycle length before reading back the page.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROG = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pgm_page_buffer.sv
module pgm_page_buffer #(
  parameter int PAGE_BYTES = 32,
  parameter int COL_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_en_i,
  input  logic [COL_W-1:0] wr_col_i,
  input  logic [7:0]       wr_byte_i,
  input  logic [COL_W-1:0] rd_col_i,
  output logic [7:0]       rd_byte_o,
  output logic             rd_hit_o,
  output logic             any_o
);
  logic [7:0]            slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) slot_q[wr_col_i] <= wr_byte_i;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                      mask_q[g] <= 1'b0;
      else if (clr_i)                                   mask_q[g] <= 1'b0;
      else if (wr_en_i && wr_col_i == COL_W'(g))        mask_q[g] <= 1'b1;
    end
  end

  assign rd_byte_o = slot_q[rd_col_i];
  assign rd_hit_o  = mask_q[rd_col_i];
  assign any_o     = |mask_q;

  AST_ANY_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !clr_i |=> any_o); // R9
endmodule

// File: rtl/pgm_cycle_timer.sv
module pgm_cycle_timer #(
  parameter int CYCLE_CLKS = 250000,
  parameter int CNT_W      = $clog2(CYCLE_CLKS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == CNT_W'(CYCLE_CLKS - 1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || last_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + CNT_W'(1);
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CYCLE_CLKS - 1)); // R3
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> cnt_q == '0); // R3
endmodule

// File: rtl/pgm_array.sv
module pgm_array #(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [7:0]        wd_i,
  input  logic              seal_i,
  output logic              wpage_init_o,
  input  logic [ADDR_W-1:0] ra_i,
  output logic [7:0]        rd_o
);
  localparam int PG_W  = ADDR_W - COL_W;
  localparam int PAGES = 1 << PG_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]       mem [DEPTH];
  logic [PAGES-1:0] init_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  // page reads erased until its first commit has filled every slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     init_q <= '0;
    else if (seal_i) init_q[wa_i[ADDR_W-1:COL_W]] <= 1'b1;
  end

  assign wpage_init_o = init_q[wa_i[ADDR_W-1:COL_W]];
  assign rd_o = init_q[ra_i[ADDR_W-1:COL_W]] ? mem[ra_i] : 8'hFF;

  AST_SEAL_WITH_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seal_i |-> we_i); // R7
endmodule

// File: rtl/pgm_sequencer.sv
module pgm_sequencer #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              wr_start_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_byte_vld_i,
  input  logic [7:0]        wr_byte_i,
  input  logic              byte_aligned_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o,
  output logic              wel_clr_o
);
  import pgm_pkg::*;

  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - COL_W;
  localparam int CNT_W = $clog2(CYCLE_CLKS);

  seq_state_e       state_q, state_d;
  logic [PG_W-1:0]  page_q, page_d;
  logic [COL_W-1:0] ptr_q, ptr_d;
  logic             cs_q, wel_clr_q;
  logic             cs_rise, buf_clr, buf_we, buf_hit, buf_any;
  logic [7:0]       buf_byte;
  logic [CNT_W-1:0] t_cnt;
  logic             t_last, commit, mem_we, seal, wpage_init;

  assign cs_rise = cs_n_i && !cs_q;
  assign busy_o  = (state_q == ST_PROG);
  assign buf_clr = (state_q == ST_IDLE) && wr_start_i;
  assign buf_we  = (state_q == ST_FILL) && wr_byte_vld_i;
  // commit runs in the final PAGE_BYTES clocks of the window
  assign commit  = busy_o && (t_cnt >= CNT_W'(CYCLE_CLKS - PAGE_BYTES));
  assign mem_we  = commit && (buf_hit || !wpage_init);
  assign seal    = commit && (&ptr_q) && !wpage_init;
  assign wel_clr_o = wel_clr_q;

  always_comb begin
    state_d = state_q;
    page_d  = page_q;
    ptr_d   = ptr_q;
    unique case (state_q)
      ST_IDLE: if (wr_start_i) begin
        state_d = ST_FILL;
        page_d  = wr_addr_i[ADDR_W-1:COL_W];
        ptr_d   = wr_addr_i[COL_W-1:0];
      end
      ST_FILL: begin
        if (wr_byte_vld_i) ptr_d = ptr_q + COL_W'(1);
        if (cs_rise) begin
          if (byte_aligned_i && buf_any) begin
            state_d = ST_PROG;
            ptr_d   = '0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_PROG: begin
        if (commit) ptr_d = ptr_q + COL_W'(1);
        if (t_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      page_q    <= '0;
      ptr_q     <= '0;
      cs_q      <= 1'b1;
      wel_clr_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      page_q    <= page_d;
      ptr_q     <= ptr_d;
      cs_q      <= cs_n_i;
      wel_clr_q <= busy_o && t_last;
    end
  end

  pgm_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (buf_clr),
    .wr_en_i   (buf_we),
    .wr_col_i  (ptr_q),
    .wr_byte_i (wr_byte_i),
    .rd_col_i  (ptr_q),
    .rd_byte_o (buf_byte),
    .rd_hit_o  (buf_hit),
    .any_o     (buf_any)
  );

  pgm_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS), .CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .cnt_o  (t_cnt),
    .last_o (t_last)
  );

  pgm_array #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (mem_we),
    .wa_i         ({page_q, ptr_q}),
    .wd_i         (buf_hit ? buf_byte : 8'hFF),
    .seal_i       (seal),
    .wpage_init_o (wpage_init),
    .ra_i         (rd_addr_i),
    .rd_o         (rd_data_o)
  );

  AST_BUSY_AFTER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_n_i) && !$past(cs_n_i, 2)); // R2
  AST_WEL_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |-> $fell(busy_o)); // R4
  AST_WEL_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |=> !wel_clr_o); // R4
  AST_NO_BUSY_UNALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL) && cs_rise && !byte_aligned_i |=> !busy_o); // R8
  AST_PAGE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(page_q)); // R10
endmodule

// File: tb/pgm_sequencer_tb.sv
module pgm_sequencer_tb;
  localparam int AW = 12;
  localparam int PB = 32;
  localparam int CC = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          wr_start = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic          vld = 1'b0;
  logic [7:0]    wr_byte = '0;
  logic          aligned = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          busy, wel_clr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit [7:0] ref_mem [1 << AW];

  always #10 clk = ~clk;

  pgm_sequencer #(.ADDR_W(AW), .PAGE_BYTES(PB), .CYCLE_CLKS(CC)) u_dut (
    .clk_i (clk), .rst_ni (rst_n), .cs_n_i (cs_n),
    .wr_start_i (wr_start), .wr_addr_i (wr_addr),
    .wr_byte_vld_i (vld), .wr_byte_i (wr_byte),
    .byte_aligned_i (aligned), .rd_addr_i (rd_addr),
    .rd_data_o (rd_data), .busy_o (busy), .wel_clr_o (wel_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input int a, input string req);
    int aa = a & ((1 << AW) - 1);
    rd_addr = AW'(aa);
    #1;
    chk(rd_data == ref_mem[aa], req, rd_data, ref_mem[aa]);
  endtask

  task automatic run_write(input int addr, input int n, input bit al, input bit poke);
    bit [7:0] dat [64];
    int base = addr & ~(PB - 1);
    int col  = addr & (PB - 1);
    int poke_addr = addr ^ 'h400;
    bit prog = al && (n > 0);
    bit bad = 1'b0;
    string rq = (n > PB) ? "R6" : "R5";
    @(negedge clk);
    cs_n = 1'b0; wr_start = 1'b1; wr_addr = AW'(addr);
    @(negedge clk);
    wr_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      dat[i] = 8'($urandom);
      if ($urandom % 4 == 0) @(negedge clk);
      vld = 1'b1; wr_byte = dat[i];
      @(negedge clk);
      vld = 1'b0;
    end
    aligned = al; cs_n = 1'b1;
    @(negedge clk);
    aligned = 1'b1;
    if (prog) begin
      chk(busy == 1'b1, "R2", busy, 1);
      for (int k = 2; k <= CC; k++) begin
        @(negedge clk);
        if (poke && k == 2) begin cs_n = 1'b0; wr_start = 1'b1; wr_addr = AW'(poke_addr); end
        if (poke && k == 3) begin wr_start = 1'b0; vld = 1'b1; wr_byte = 8'h5A; end
        if (poke && k == 4) begin vld = 1'b0; cs_n = 1'b1; end
      end
      chk(busy == 1'b1, "R3", busy, 1);
      @(negedge clk);
      chk(busy == 1'b0, "R3", busy, 0);
      chk(wel_clr == 1'b1, "R4", wel_clr, 1);
      for (int i = 0; i < n; i++) ref_mem[base + ((col + i) & (PB - 1))] = dat[i];
      @(negedge clk);
      chk(wel_clr == 1'b0, "R4", wel_clr, 0);
      if (poke) begin
        repeat (CC + 2) begin @(negedge clk); if (busy) bad = 1'b1; end
        chk(!bad, "R10", bad, 0);
        rd_chk(poke_addr, "R10");
      end
    end else begin
      chk(busy == 1'b0, (n == 0) ? "R9" : "R8", busy, 0);
      repeat (CC + 4) begin @(negedge clk); if (busy || wel_clr) bad = 1'b1; end
      chk(!bad, (n == 0) ? "R9" : "R8", bad, 0);
    end
    for (int c = 0; c < PB; c++) rd_chk(base + c, prog ? rq : (n == 0 ? "R9" : "R8"));
    rd_chk(base + PB, "R7");
    rd_chk(base - 1, "R7");
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(wel_clr == 1'b0, "R1", wel_clr, 0);
    rd_chk(0, "R1"); rd_chk('h7A3, "R1"); rd_chk('hFFF, "R1");

    run_write('h01E, 5, 1'b1, 1'b0);   // wrap inside page
    run_write('h100, 40, 1'b1, 1'b0);  // overflow, last wins
    run_write('h120, 0, 1'b1, 1'b0);   // no data byte
    run_write('h200, 3, 1'b0, 1'b0);   // unaligned release
    run_write('h300, 4, 1'b1, 1'b1);   // pokes during busy
    run_write('hFFF, 2, 1'b1, 1'b0);   // top page wrap
    run_write('h105, 3, 1'b1, 1'b0);   // rewrite of programmed page
    for (int r = 0; r < 16; r++)
      run_write(int'($urandom % (1 << AW)), int'(1 + $urandom % 36),
                ($urandom % 6) != 0, 1'b0);
    for (int r = 0; r < 24; r++) rd_chk(int'($urandom % (1 << AW)), "R7");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule